// File: doc/BRIEF.md
# Decimal Adjust Flag Unit

This block corrects an 8-bit accumulator after a binary add or subtract so that the result holds two packed BCD digits. It also produces the full flag byte that such a correction leaves behind. The block looks at the two nibbles of the accumulator, the carry flag, the half-carry flag and the subtract flag. From these it picks a correction constant of 0x00, 0x06, 0x60 or 0x66. When the subtract flag is clear it adds that constant, and when it is set it subtracts it. Both operations are modulo 256.

The computation is purely combinational. A thin registered stage around it captures a request when a valid strobe arrives and presents the result one clock later. The stage holds that result until the next strobe, so a datapath can treat the block as a single-cycle ALU operation.

Top module: `daa_unit`

## Requirements
- R1: Correction selection. Let lo be accumulator bits 3..0 and hi be bits 7..4, both taken before adjustment.
  - Carry set: the constant is 0x60 if lo<=9 and half-carry is clear, and 0x66 otherwise.
  - Carry clear and lo>=10: the constant is 0x06 if hi<=8, and 0x66 otherwise.
  - Carry clear, lo<=9 and hi>=10: the constant is 0x66 if half-carry is set, and 0x60 otherwise.
  - Carry clear and both nibbles <=9: the constant is 0x06 if half-carry is set, and 0x00 otherwise.
- R2: With subtract clear, result = accumulator + constant mod 256. With subtract set, result = accumulator - constant mod 256.
- R3: Carry out is set when carry in is set. Otherwise it is set when hi>=10 with lo<=9, or when hi>=9 with lo>=10.
- R4: Half-carry out. With subtract clear it is (lo>=10). With subtract set it is half-carry in AND (lo<=5).
- R5: Sign is result bit 7, zero is (result==0), and parity/overflow is set when the result has an even number of ones.
- R6: Undocumented flag bits 5 and 3 copy result bits 5 and 3. The subtract flag is passed through unchanged.
- R7: The flag byte is packed as {S,Z,F5,H,F3,PV,N,C} from bit 7 down to bit 0.
- R8: out_valid rises exactly one clock after in_valid. Results and flags hold while in_valid is low. After reset, out_valid, the result and the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe |
| acc_in | input | 8 | Accumulator before adjustment |
| cy_in | input | 1 | Carry flag in |
| hc_in | input | 1 | Half-carry flag in |
| sub_in | input | 1 | Subtract flag in |
| out_valid | output | 1 | Result valid, one clock after strobe |
| acc_out | output | 8 | Adjusted accumulator |
| flags_out | output | 8 | Flags {S,Z,F5,H,F3,PV,N,C} |

## Verification
Assertions check on every cycle that the registered flag byte agrees with the registered result: sign, zero, parity and the two copied bits must match. They also check that the strobe-to-valid latency is one clock, that outputs hold between strobes, and that carry out is never cleared when carry in was set. Whether the chosen correction constant and the half-carry rule are right for each direction can only be shown by the bench. It sweeps every accumulator value against all eight flag combinations and compares the results with an independent model.

// File: rtl/daa_pkg.sv
package daa_pkg;
    parameter int W = 8;
    localparam int NW = W / 2;

    typedef struct packed {
        logic s;
        logic z;
        logic f5;
        logic h;
        logic f3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] acc;
        flags_t       flg;
    } out_t;
endpackage

// File: rtl/daa_corr.sv
module daa_corr
    import daa_pkg::*;
(
    input  logic [W-1:0] acc,
    input  logic         cy,
    input  logic         hc,
    output logic [W-1:0] corr,
    output logic         cy_out
);
    logic [NW-1:0] lo, hi;
    logic lo_big, hi_big, hi_ge9;

    always_comb begin
        lo     = acc[NW-1:0];
        hi     = acc[W-1:NW];
        lo_big = (lo >= NW'(10));
        hi_big = (hi >= NW'(10));
        hi_ge9 = (hi >= NW'(9));
        if (cy)
            corr = (!lo_big && !hc) ? 8'h60 : 8'h66;
        else if (lo_big)
            corr = (hi <= NW'(8)) ? 8'h06 : 8'h66;
        else if (hi_big)
            corr = hc ? 8'h66 : 8'h60;
        else
            corr = hc ? 8'h06 : 8'h00;
        cy_out = cy | (lo_big ? hi_ge9 : hi_big);
    end
endmodule

// File: rtl/daa_flags.sv
module daa_flags
    import daa_pkg::*;
(
    input  logic [W-1:0] acc,
    input  logic [W-1:0] res,
    input  logic         hc,
    input  logic         sub,
    input  logic         cy_out,
    output flags_t       flg
);
    logic [NW-1:0] lo;

    always_comb begin
        lo     = acc[NW-1:0];
        flg.s  = res[W-1];
        flg.z  = (res == '0);
        flg.f5 = res[5];
        flg.f3 = res[3];
        flg.pv = ~^res;
        flg.n  = sub;
        flg.h  = sub ? (hc && lo <= NW'(5)) : (lo >= NW'(10));
        flg.c  = cy_out;
    end
endmodule

// File: rtl/daa_unit.sv
module daa_unit
    import daa_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   acc_in,
    input  logic         cy_in,
    input  logic         hc_in,
    input  logic         sub_in,
    output logic         out_valid,
    output logic [7:0]   acc_out,
    output logic [7:0]   flags_out
);
    logic [W-1:0] corr, res;
    logic         cy_o;
    flags_t       flg;
    out_t         st_d, st_q;

    daa_corr u_corr (.acc(acc_in), .cy(cy_in), .hc(hc_in), .corr(corr), .cy_out(cy_o));

    always_comb res = sub_in ? (acc_in - corr) : (acc_in + corr);

    daa_flags u_flags (.acc(acc_in), .res(res), .hc(hc_in), .sub(sub_in),
                       .cy_out(cy_o), .flg(flg));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.acc = res;
            st_d.flg = flg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign acc_out   = st_q.acc;
    assign flags_out = st_q.flg;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_out) && $stable(flags_out))); // R8
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[7] == acc_out[7] && flags_out[6] == (acc_out == 8'h00))); // R5
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[2] == ~^acc_out)); // R5
    AST_XY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[5] == acc_out[5] && flags_out[3] == acc_out[3])); // R6
    AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cy_in) |=> flags_out[0]); // R3
    AST_N_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags_out[1] == $past(sub_in))); // R6
endmodule

// File: tb/test_daa_unit.sv
module test_daa_unit;
    logic clk = 0, rst_n = 0, in_valid = 0, cy_in = 0, hc_in = 0, sub_in = 0;
    logic [7:0] acc_in = 0;
    logic out_valid;
    logic [7:0] acc_out, flags_out;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    daa_unit i_daa_unit (.clk, .rst_n, .in_valid, .acc_in, .cy_in, .hc_in, .sub_in,
                         .out_valid, .acc_out, .flags_out);

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int a, input bit c, h, n, output int r, output int f);
        int lo, hi, k, cnt;
        bit co, ho;
        lo = a % 16; hi = a / 16;
        // R1 decision ladder written from the requirement
        if (c) k = (lo < 10 && !h) ? 96 : 102;
        else if (lo > 9) k = (hi < 9) ? 6 : 102;
        else if (hi > 9) k = h ? 102 : 96;
        else k = h ? 6 : 0;
        r = n ? (a - k + 256) % 256 : (a + k) % 256;   // R2
        co = c || (lo > 9 ? hi > 8 : hi > 9);          // R3
        ho = n ? (h && lo < 6) : (lo > 9);             // R4
        cnt = 0;
        for (int i = 0; i < 8; i++) cnt += (r >> i) & 1;
        f = ((r >> 7) & 1) * 128 + (r == 0) * 64 + ((r >> 5) & 1) * 32 + ho * 16
          + ((r >> 3) & 1) * 8 + (cnt % 2 == 0) * 4 + n * 2 + co;  // R5 R6 R7
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r, f;
        repeat (3) @(posedge clk);
        #2;
        chk("R8 reset valid", out_valid, 0);
        chk("R8 reset acc", acc_out, 0);
        chk("R8 reset flags", flags_out, 0);
        rst_n = 1;
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                acc_in = 8'(a); cy_in = m[0]; hc_in = m[1]; sub_in = m[2]; in_valid = 1;
                @(negedge clk);
                in_valid = 0;
                model(a, m[0], m[1], m[2], r, f);
                chk("R8 valid", out_valid, 1);
                chk("R1 R2 acc", acc_out, r);
                chk("R3 R4 R5 R6 R7 flags", flags_out, f);
            end
        end
        // R8 hold: change inputs without strobe
        acc_in = 8'h9A; cy_in = 1; sub_in = 0;
        @(negedge clk);
        chk("R8 drop valid", out_valid, 0);
        model(255, 1, 1, 1, r, f);
        chk("R8 hold acc", acc_out, r);
        chk("R8 hold flags", flags_out, f);
        // directed corner: 0x9A add -> 0x00 with carry
        in_valid = 1; hc_in = 0;
        @(negedge clk);
        in_valid = 0;
        chk("R1 9A add", acc_out, 8'h00);
        chk("R5 9A zero flag", flags_out[6], 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule